// File: doc/BRIEF.md
# Translation Unit Table Configuration Register File

This block is the software-visible configuration store of a memory-resident interrupt translation unit. It holds a control word, a command-queue base word, the command-queue write and read pointers, and eight table base slots. Of the eight slots only two are implemented: slot 0 describes the device table and slot 1 the collection table. Every register is 64 bits wide. It can be reached with one 64-bit access or with a 32-bit access to either half, where bus address bit 2 selects the upper half.

From the stored words the block works out the geometry of each table and of the command queue: base address, page size, entry size, entry count, flat or indirect layout, and a valid flag. It latches that geometry into output registers when software sets the enable bit. A one-cycle pulse then tells the downstream walkers that fresh parameters are in place. While the unit is enabled, the base words are frozen.

Register map (byte offsets): control at 0x00, command-queue base at 0x08, write pointer at 0x10, read pointer at 0x18, table slot n at 0x40 + 8·n. Reads are combinational: `bus_rdata` reflects `bus_addr` and `bus_wide` in the same cycle. A 32-bit read returns its half in bits 31:0.

Top module: `tcfg_regs`

## Requirements
- R1: After reset the control word reads 0x8000_0000: bit 31 is the quiescent flag, held at 1, and bit 0 is the enable, at 0. Slot 0 reads type 1 in bits 58:56, slot 1 reads type 4, and both read entry-size field (entry bytes − 1) in bits 52:48 and page code 2 in bits 11:10. Slots 2 to 7 always read zero and ignore writes.
- R2: The page code in bits 11:10 of a table word selects the page size: code 0 means 4 KB, code 1 means 16 KB, and codes 2 and 3 both mean 64 KB. The page size is reported as a shift of 12, 14 or 16.
- R3: For 4 KB and 16 KB pages, the table base is bits 47:12 of the table word placed at address bit 12. For 64 KB pages, bits 47:16 are placed at address bit 16 and bits 15:12 at address bits 51:48.
- R4: A table's page count is bits 7:0 plus 1, and its entry size is bits 52:48 plus 1. A flat table (bit 62 clear) holds pages·page_size/entry_size entries.
- R5: An indirect table (bit 62 set) holds (pages·page_size/8)·(page_size/entry_size) entries. The valid flag is bit 63.
- R6: The command queue holds (bits 7:0 + 1)·4096/32 entries of its base word. Its base is bits 47:12 kept in place, and its valid flag is bit 63.
- R7: Writes to the table words and to the command-queue base are ignored while enable is set. An accepted write to the command-queue base clears both pointers.
- R8: A 32-bit write to either half of a table word leaves the other half and the read-only type (58:56) and entry-size (52:48) bits unchanged.
- R9: A write of 1 to control bit 0 sets enable, clears the read pointer, captures all table and queue parameters, and raises `cfg_load` for exactly one cycle. All of these are visible after the clock edge that accepts the write.
- R10: The read pointer accepts writes only while `sec_disable` is high, and bit 0 (stalled) is forced to 0. Bit 0 (retry) of the write pointer is always forced to 0. The queue index of each pointer is bits 19:5.
- R11: Unmapped accesses read zero and are ignored on write. These are undefined offsets, addresses not aligned to 4 bytes, and 64-bit accesses with address bit 2 set.
- R12: A write of 0 to control bit 0 clears enable and leaves the captured parameters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_disable | input | 1 | Global security-disable; permits read-pointer writes |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 64 | Write data (bits 31:0 for a 32-bit access) |
| bus_rdata | output | 64 | Combinational read data |
| unit_en | output | 1 | Enable bit |
| cfg_load | output | 1 | One-cycle pulse after parameter capture |
| tbl_valid | output | 2 | Captured valid flag per table |
| tbl_indirect | output | 2 | Captured indirect flag per table |
| tbl_base | output | 2×52 | Captured base address per table |
| tbl_page_shift | output | 2×5 | Captured log2 page size per table |
| tbl_entry_bytes | output | 2×6 | Captured entry size in bytes per table |
| tbl_entries | output | 2×40 | Captured entry count per table |
| cq_valid | output | 1 | Captured command-queue valid flag |
| cq_base | output | 52 | Captured command-queue base |
| cq_entries | output | 16 | Captured command-queue entry count |
| cq_wr_idx | output | 15 | Live write-pointer queue index |
| cq_rd_idx | output | 15 | Live read-pointer queue index |

## Verification
The enabling write does two things at the same clock edge: it captures the parameters and it clears the read pointer. The write that follows it then meets the newly set lock. The bench sets up nonzero pointers before the enable and issues a table-word write straight after it. It then checks three things: the captured values reflect the words from before the enable, the read index is zero while the write index is kept, and the late table write reads back unchanged. A behavioural model compares every captured output with expected values on each clock.

// File: rtl/tcfg_regs.sv
module tcfg_regs #(
  parameter int DEV_ENTRY_BYTES = 8,
  parameter int COL_ENTRY_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_disable,
  input  logic                   bus_wr,
  input  logic                   bus_wide,
  input  logic [7:0]             bus_addr,
  input  logic [63:0]            bus_wdata,
  output logic [63:0]            bus_rdata,
  output logic                   unit_en,
  output logic                   cfg_load,
  output logic [1:0]             tbl_valid,
  output logic [1:0]             tbl_indirect,
  output logic [1:0][51:0]       tbl_base,
  output logic [1:0][4:0]        tbl_page_shift,
  output logic [1:0][5:0]        tbl_entry_bytes,
  output logic [1:0][39:0]       tbl_entries,
  output logic                   cq_valid,
  output logic [51:0]            cq_base,
  output logic [15:0]            cq_entries,
  output logic [14:0]            cq_wr_idx,
  output logic [14:0]            cq_rd_idx
);
  localparam int NT     = 2;
  localparam int CNT_W  = 40;
  localparam logic [63:0] TBL_RO = 64'h071F_0000_0000_0000;

  function automatic logic [63:0] rst_val(input int i);
    logic [63:0] v;
    v = '0;
    v[58:56] = (i == 0) ? 3'd1 : 3'd4;
    v[52:48] = (i == 0) ? 5'(DEV_ENTRY_BYTES - 1) : 5'(COL_ENTRY_BYTES - 1);
    v[11:10] = 2'd2;
    return v;
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] wd,
                                        input logic wide, input logic hi, input logic [63:0] ro);
    logic [63:0] n;
    n = wide ? wd : (hi ? {wd[31:0], old[31:0]} : {old[63:32], wd[31:0]});
    return (n & ~ro) | (old & ro);
  endfunction

  logic             en_q, load_q;
  logic [63:0]      cqb_q, wp_q, rp_q;
  logic [NT-1:0][63:0] tbl_q;

  wire       hi      = bus_addr[2];
  wire [4:0] word    = bus_addr[7:3];
  wire       legal   = (bus_addr[1:0] == 2'b00) && !(bus_wide && hi);
  wire       sel_ctl = legal && word == 5'd0;
  wire       sel_cqb = legal && word == 5'd1;
  wire       sel_wp  = legal && word == 5'd2;
  wire       sel_rp  = legal && word == 5'd3;
  wire       sel_tbl = legal && bus_addr[7:6] == 2'b01;

  logic [NT-1:0][51:0]      base_d;
  logic [NT-1:0][4:0]       psh_d;
  logic [NT-1:0][CNT_W-1:0] cnt_d;

  for (genvar i = 0; i < NT; i++) begin : g_tbl
    localparam int ESH = (i == 0) ? $clog2(DEV_ENTRY_BYTES) : $clog2(COL_ENTRY_BYTES);
    wire [1:0]       pc    = tbl_q[i][11:10];
    wire [8:0]       pages = {1'b0, tbl_q[i][7:0]} + 9'd1;
    wire [CNT_W-1:0] bytes = CNT_W'(pages) << psh_d[i];
    assign psh_d[i]  = (pc == 2'd0) ? 5'd12 : (pc == 2'd1) ? 5'd14 : 5'd16;
    assign base_d[i] = pc[1] ? {tbl_q[i][15:12], tbl_q[i][47:16], 16'h0}
                             : {4'h0, tbl_q[i][47:12], 12'h0};
    assign cnt_d[i]  = tbl_q[i][62] ? ((bytes >> 3) << (psh_d[i] - 5'(ESH)))
                                    : (bytes >> ESH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; load_q <= 1'b0;
      cqb_q <= '0; wp_q <= '0; rp_q <= '0;
      for (int i = 0; i < NT; i++) tbl_q[i] <= rst_val(i);
      tbl_valid <= '0; tbl_indirect <= '0; tbl_base <= '0;
      tbl_page_shift <= '0; tbl_entry_bytes <= '0; tbl_entries <= '0;
      cq_valid <= 1'b0; cq_base <= '0; cq_entries <= '0;
    end else begin
      load_q <= 1'b0;
      if (bus_wr) begin
        if (sel_ctl && !hi) begin
          if (bus_wdata[0]) begin
            en_q   <= 1'b1;
            rp_q   <= '0;
            load_q <= 1'b1;
            for (int i = 0; i < NT; i++) begin
              tbl_valid[i]       <= tbl_q[i][63];
              tbl_indirect[i]    <= tbl_q[i][62];
              tbl_base[i]        <= base_d[i];
              tbl_page_shift[i]  <= psh_d[i];
              tbl_entry_bytes[i] <= 6'(tbl_q[i][52:48]) + 6'd1;
              tbl_entries[i]     <= cnt_d[i];
            end
            cq_valid   <= cqb_q[63];
            cq_base    <= {4'h0, cqb_q[47:12], 12'h0};
            cq_entries <= (16'(cqb_q[7:0]) + 16'd1) << 7;
          end else begin
            en_q <= 1'b0;
          end
        end
        if (sel_cqb && !en_q) begin
          cqb_q <= merge(cqb_q, bus_wdata, bus_wide, hi, '0);
          wp_q  <= '0;
          rp_q  <= '0;
        end
        if (sel_wp) wp_q <= merge(wp_q, bus_wdata, bus_wide, hi, '0) & ~64'd1;
        if (sel_rp && sec_disable) rp_q <= merge(rp_q, bus_wdata, bus_wide, hi, '0) & ~64'd1;
        for (int i = 0; i < NT; i++)
          if (sel_tbl && bus_addr[5:3] == 3'(i) && !en_q)
            tbl_q[i] <= merge(tbl_q[i], bus_wdata, bus_wide, hi, TBL_RO);
      end
    end
  end

  logic [63:0] full;
  always_comb begin
    full = '0;
    if (sel_ctl)      full = {32'h0, 1'b1, 30'h0, en_q};
    else if (sel_cqb) full = cqb_q;
    else if (sel_wp)  full = wp_q;
    else if (sel_rp)  full = rp_q;
    else if (sel_tbl && bus_addr[5:3] < 3'(NT)) full = tbl_q[bus_addr[3]];
  end

  assign bus_rdata = !legal ? '0 : bus_wide ? full : {32'h0, hi ? full[63:32] : full[31:0]};
  assign unit_en   = en_q;
  assign cfg_load  = load_q;
  assign cq_wr_idx = wp_q[19:5];
  assign cq_rd_idx = rp_q[19:5];

  assert_lock_tbl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && bus_wr && sel_tbl) |=> $stable(tbl_q));
  assert_cq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && bus_wr && sel_cqb) |=> (cq_wr_idx == 15'd0 && cq_rd_idx == 15'd0));
  assert_rp_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_rp && !sec_disable) |=> $stable(rp_q));
  assert_load_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> (unit_en && cq_rd_idx == 15'd0));
  assert_capture_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tbl_entries) |-> cfg_load);
  assert_disable_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctl && !hi && !bus_wdata[0]) |=> (!unit_en && $stable(tbl_base)));
endmodule

// File: tb/sim_tcfg_regs.sv
module sim_tcfg_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] RO = 64'h071F_0000_0000_0000;

  logic clk = 0, rst_n = 0, sec = 0, b_wr = 0, b_wide = 0;
  logic [7:0] b_addr = 0;
  logic [63:0] b_wd = 0;
  logic [63:0] rdata;
  logic unit_en, cfg_load, cq_valid;
  logic [1:0] tbl_valid, tbl_indirect;
  logic [1:0][51:0] tbl_base;
  logic [1:0][4:0] tbl_page_shift;
  logic [1:0][5:0] tbl_entry_bytes;
  logic [1:0][39:0] tbl_entries;
  logic [51:0] cq_base;
  logic [15:0] cq_entries;
  logic [14:0] cq_wr_idx, cq_rd_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcfg_regs u0 (.clk, .rst_n, .sec_disable(sec), .bus_wr(b_wr), .bus_wide(b_wide),
    .bus_addr(b_addr), .bus_wdata(b_wd), .bus_rdata(rdata), .unit_en, .cfg_load,
    .tbl_valid, .tbl_indirect, .tbl_base, .tbl_page_shift, .tbl_entry_bytes,
    .tbl_entries, .cq_valid, .cq_base, .cq_entries, .cq_wr_idx, .cq_rd_idx);

  int checks = 0, errs = 0, cyc = 0;
  bit done = 0;

  // behavioural reference model
  bit m_en, m_load;
  logic [63:0] m_cqb, m_wp, m_rp;
  logic [63:0] m_tbl [2];
  longint e_base[2], e_cnt[2], e_psh[2], e_eb[2], e_val[2], e_ind[2];
  longint e_cqb, e_cqn, e_cqv;

  function automatic longint psz(logic [63:0] r);
    return (r[11:10] == 0) ? 4096 : (r[11:10] == 1) ? 16384 : 65536;
  endfunction
  function automatic longint m_base(logic [63:0] r);
    if (r[11:10] >= 2) return longint'(r[47:16]) * 65536 + longint'(r[15:12]) * (longint'(1) << 48);
    return longint'(r[47:12]) * 4096;
  endfunction
  function automatic longint m_cnt(logic [63:0] r);
    longint pages = longint'(r[7:0]) + 1;
    longint esz = longint'(r[52:48]) + 1;
    if (r[62]) return (pages * psz(r) / 8) * (psz(r) / esz);
    return pages * psz(r) / esz;
  endfunction
  function automatic logic [63:0] mrg(logic [63:0] o, logic [63:0] d, bit wide, bit hi, logic [63:0] ro);
    logic [63:0] n;
    if (wide) n = d; else if (hi) n = {d[31:0], o[31:0]}; else n = {o[63:32], d[31:0]};
    return (n & ~ro) | (o & ro);
  endfunction
  function automatic logic [63:0] m_read(logic [7:0] a, bit wide);
    logic [63:0] f;
    if (a[1:0] != 0 || (wide && a[2])) return 0;
    case (a & 8'hF8)
      8'h00: f = 64'h8000_0000 | 64'(m_en);
      8'h08: f = m_cqb;
      8'h10: f = m_wp;
      8'h18: f = m_rp;
      8'h40: f = m_tbl[0];
      8'h48: f = m_tbl[1];
      default: f = 0;
    endcase
    if (wide) return f;
    return a[2] ? {32'h0, f[63:32]} : {32'h0, f[31:0]};
  endfunction

  task automatic m_reset();
    m_en = 0; m_load = 0; m_cqb = 0; m_wp = 0; m_rp = 0;
    m_tbl[0] = (64'd1 << 56) | (64'd7 << 48) | (64'd2 << 10);
    m_tbl[1] = (64'd4 << 56) | (64'd7 << 48) | (64'd2 << 10);
    for (int j = 0; j < 2; j++) begin
      e_base[j] = 0; e_cnt[j] = 0; e_psh[j] = 0; e_eb[j] = 0; e_val[j] = 0; e_ind[j] = 0;
    end
    e_cqb = 0; e_cqn = 0; e_cqv = 0;
  endtask

  task automatic m_write(logic [7:0] a, bit wide, logic [63:0] d);
    bit hi = a[2];
    if (a[1:0] != 0 || (wide && hi)) return;
    case (a & 8'hF8)
      8'h00: if (!hi) begin
        if (d[0]) begin
          for (int j = 0; j < 2; j++) begin
            e_base[j] = m_base(m_tbl[j]); e_cnt[j] = m_cnt(m_tbl[j]);
            e_psh[j] = (psz(m_tbl[j]) == 4096) ? 12 : (psz(m_tbl[j]) == 16384) ? 14 : 16;
            e_eb[j] = longint'(m_tbl[j][52:48]) + 1;
            e_val[j] = m_tbl[j][63]; e_ind[j] = m_tbl[j][62];
          end
          e_cqb = longint'(m_cqb[47:12]) * 4096;
          e_cqn = (longint'(m_cqb[7:0]) + 1) * 4096 / 32;
          e_cqv = m_cqb[63];
          m_en = 1; m_rp = 0; m_load = 1;
        end else m_en = 0;
      end
      8'h08: if (!m_en) begin m_cqb = mrg(m_cqb, d, wide, hi, 0); m_wp = 0; m_rp = 0; end
      8'h10: m_wp = mrg(m_wp, d, wide, hi, 0) & ~64'd1;
      8'h18: if (sec) m_rp = mrg(m_rp, d, wide, hi, 0) & ~64'd1;
      8'h40: if (!m_en) m_tbl[0] = mrg(m_tbl[0], d, wide, hi, RO);
      8'h48: if (!m_en) m_tbl[1] = mrg(m_tbl[1], d, wide, hi, RO);
      default: ;
    endcase
  endtask

  always @(posedge clk) if (rst_n) begin
    m_load = 0;
    if (b_wr) m_write(b_addr, b_wide, b_wd);
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R9 unit_en", 64'(unit_en), 64'(m_en));
    chk("R9 cfg_load", 64'(cfg_load), 64'(m_load));
    for (int j = 0; j < 2; j++) begin
      chk("R3 tbl_base", 64'(tbl_base[j]), e_base[j]);
      chk("R4 tbl_entries", 64'(tbl_entries[j]), e_cnt[j]);
      chk("R2 tbl_page_shift", 64'(tbl_page_shift[j]), e_psh[j]);
      chk("R4 tbl_entry_bytes", 64'(tbl_entry_bytes[j]), e_eb[j]);
      chk("R5 tbl_valid", 64'(tbl_valid[j]), e_val[j]);
      chk("R5 tbl_indirect", 64'(tbl_indirect[j]), e_ind[j]);
    end
    chk("R6 cq_base", 64'(cq_base), e_cqb);
    chk("R6 cq_entries", 64'(cq_entries), e_cqn);
    chk("R6 cq_valid", 64'(cq_valid), e_cqv);
    chk("R10 cq_wr_idx", 64'(cq_wr_idx), 64'(m_wp[19:5]));
    chk("R10 cq_rd_idx", 64'(cq_rd_idx), 64'(m_rp[19:5]));
  end

  task automatic wr(logic [7:0] a, bit wide, logic [63:0] d);
    b_wr = 1; b_addr = a; b_wide = wide; b_wd = d;
    @(negedge clk);
    b_wr = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, bit wide, logic [63:0] exp);
    b_addr = a; b_wide = wide;
    #1;
    chk(req, rdata, exp);
    chk(req, rdata, m_read(a, wide));
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errs++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd("R1 ctrl", 8'h00, 0, 64'h8000_0000);
    rd("R1 slot0", 8'h40, 1, 64'h0107_0000_0000_0800);
    rd("R1 slot1", 8'h48, 1, 64'h0407_0000_0000_0800);
    rd("R1 slot5", 8'h68, 1, 64'h0);
    wr(8'h58, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R1 slot3 ignores writes", 8'h58, 1, 64'h0);
    // R8 full write with RO bits attempted
    wr(8'h40, 1, 64'h8700_00AB_CDEF_0003);
    rd("R8 slot0 RO kept", 8'h40, 1, 64'h8107_00AB_CDEF_0003);
    wr(8'h48, 0, 64'hDEAD_0401);
    rd("R8 slot1 low half", 8'h48, 1, 64'h0407_0000_DEAD_0401);
    wr(8'h4C, 0, 64'h4000_0012);
    rd("R8 slot1 high half", 8'h48, 1, 64'h4407_0012_DEAD_0401);
    rd("R8 slot1 32-bit upper read", 8'h4C, 0, 64'h4407_0012);
    // R10 pointers
    wr(8'h10, 1, 64'h41);
    rd("R10 retry masked", 8'h10, 1, 64'h40);
    wr(8'h18, 1, 64'h61);
    rd("R10 rp write blocked", 8'h18, 1, 64'h0);
    sec = 1;
    wr(8'h18, 1, 64'h61);
    rd("R10 stalled masked", 8'h18, 1, 64'h60);
    // R7 cq base clears both pointers
    wr(8'h08, 1, 64'h8000_0000_0007_7001);
    chk("R7 cq write clears wr idx", 64'(cq_wr_idx), 0);
    chk("R7 cq write clears rd idx", 64'(cq_rd_idx), 0);
    wr(8'h10, 0, 64'h81);
    wr(8'h18, 0, 64'h21);
    chk("R10 rd idx", 64'(cq_rd_idx), 1);
    // R9 enable capture; concurrent lock
    wr(8'h00, 0, 64'h1);
    chk("R9 cfg_load pulse", 64'(cfg_load), 1);
    chk("R9 rd idx cleared", 64'(cq_rd_idx), 0);
    chk("R9 wr idx kept", 64'(cq_wr_idx), 4);
    chk("R3 base 4K", 64'(tbl_base[0]), 64'h00AB_CDEF_0000);
    chk("R4 flat entries", 64'(tbl_entries[0]), 2048);
    chk("R5 indirect entries", 64'(tbl_entries[1]), 64'h80_0000);
    chk("R2 16K shift", 64'(tbl_page_shift[1]), 14);
    chk("R6 cq entries", 64'(cq_entries), 256);
    chk("R6 cq base", 64'(cq_base), 64'h7_7000);
    wr(8'h40, 1, 64'h8000_1234_5678_AC00);
    chk("R9 pulse one cycle", 64'(cfg_load), 0);
    rd("R7 slot0 locked", 8'h40, 1, 64'h8107_00AB_CDEF_0003);
    wr(8'h08, 1, 64'h0);
    rd("R7 cq base locked", 8'h08, 1, 64'h8000_0000_0007_7001);
    chk("R7 ptrs not cleared", 64'(cq_wr_idx), 4);
    // R12 disable holds
    wr(8'h00, 0, 64'h0);
    chk("R12 enable cleared", 64'(unit_en), 0);
    chk("R12 params held", 64'(tbl_entries[0]), 2048);
    // R2/R3 64K path
    wr(8'h40, 1, 64'h8000_1234_5678_AC00);
    wr(8'h00, 1, 64'h1);
    chk("R3 base 64K", 64'(tbl_base[0]), 64'hA_1234_5678_0000);
    chk("R2 code 3 shift", 64'(tbl_page_shift[0]), 16);
    chk("R4 64K flat entries", 64'(tbl_entries[0]), 8192);
    // R11 unmapped
    rd("R11 undefined offset", 8'h30, 1, 64'h0);
    wr(8'h30, 1, 64'hFFFF);
    rd("R11 undefined after write", 8'h30, 1, 64'h0);
    wr(8'h14, 1, 64'hFFFF_FFFF);
    rd("R11 wide at high half", 8'h14, 1, 64'h0);
    rd("R11 wp untouched", 8'h10, 1, 64'h80);
    rd("R11 misaligned", 8'h11, 0, 64'h0);
    wr(8'h00, 0, 64'h0);
    wr(8'h42, 0, 64'h0);
    rd("R11 misaligned write ignored", 8'h40, 1, 64'h8107_1234_5678_AC00);
    idle_end();
  end

  task automatic idle_end();
    repeat (2) @(negedge clk);
    finish_run();
  endtask
endmodule